// File: doc/BRIEF.md
# Flash Mass-Erase Sequencer

This block runs a whole-array erase of one embedded flash instance on behalf of software. Software reaches three registers over a simple single-cycle write port with a combinational read port. The control word holds a protection key, a command code and a start bit, and shows a busy indication. A divider word sets the flash timing strobe. A flag word holds two result flags and their interrupt enables. The flash side gets a level erase request and a timing strobe. It answers with an erase-done pulse and an error level.

An erase is launched only by a control write whose key field equals the unlock value (2) and whose command field equals the erase command (0xAA) in that same write, with the start bit set. While the erase runs, the start and busy bits read as 1. Completion clears both bits and posts a done flag, plus a fail flag if the flash reported an error. A start write with the wrong key or command posts done and fail at once and leaves the flash untouched. A registered interrupt line reports any enabled flag.

Top module: `flash_wipe_ctl`

## Requirements
- R1: After reset every register field reads 0, and irq_o, fl_erase_req_o and fl_tick_o are 0.
- R2: A write to address 0 with bit 16 set, key bits [3:0] = 2 and command bits [15:8] = 0xAA, made while idle, raises fl_erase_req_o and read bits 16 (start) and 17 (busy) from the next cycle on.
- R3: A start write made while idle with any other key or command never raises fl_erase_req_o and sets done (address 2 bit 0) and fail (address 2 bit 1) in the same edge.
- R4: A start write made while an erase runs is ignored: the running erase keeps its length and posts exactly one result, and a bad key or command in that write does not set fail.
- R5: While busy, an fl_erase_done_i pulse clears start, busy and fl_erase_req_o on the next edge and sets done, and it sets fail exactly when fl_error_i is high in that cycle.
- R6: With divider value D (address 1 bits [7:0]), fl_tick_o pulses in every (D+1)-th cycle of an erase, counted from its first busy cycle, and stays 0 while idle.
- R7: Writing 1 to a flag bit at address 2 clears that flag, and writing 0 leaves it unchanged.
- R8: When a completion or a rejected start sets a flag in the same edge as a write-1 clear of that flag, the flag ends up set.
- R9: irq_o is, one cycle later, the OR of done AND done-enable (address 2 bit 8) with fail AND fail-enable (address 2 bit 9).
- R10: The key, command, divider and enable fields read back as last written. A later write of any key other than 2 relocks the flash, so a start bit in that write is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 divider, 2 flags) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| fl_erase_req_o | output | 1 | Erase request to the flash, held while busy |
| fl_tick_o | output | 1 | Divided timing strobe to the flash |
| fl_erase_done_i | input | 1 | Erase-finished pulse from the flash |
| fl_error_i | input | 1 | Erase error from the flash, valid with the done pulse |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The contended case is an erase that completes in the same edge as a software write-1 clear of its result flags. The bench waits until the flash model raises its done pulse and then presents the clear in that same cycle, with the model reporting an error. Both flags must read 1 afterwards, because setting takes priority. A second collision is a start write that arrives while busy. The bench judges it by an unchanged erase length, an unchanged tick count and a clean fail flag.

// File: rtl/flash_wipe_pkg.sv
package flash_wipe_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 4;
  localparam int CMD_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;

  localparam int KEY_LSB   = 0;
  localparam int CMD_LSB   = 8;
  localparam int START_BIT = 16;
  localparam int BUSY_BIT  = 17;
  localparam int DONE_BIT  = 0;
  localparam int FAIL_BIT  = 1;
  localparam int DEN_BIT   = 8;
  localparam int FEN_BIT   = 9;

  typedef enum logic {SEQ_IDLE, SEQ_ERASE} seq_state_e;
endpackage

// File: rtl/flash_wipe_div.sv
module flash_wipe_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == div);
  assign tick = run && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flash_wipe_seq.sv
module flash_wipe_seq
  import flash_wipe_pkg::*;
#(
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 4'h2,
  parameter logic [CMD_W-1:0] ERASE_CMD  = 8'hAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [CMD_W-1:0] wr_cmd,
  input  logic             erase_done,
  input  logic             erase_err,
  output logic             busy,
  output logic             set_done,
  output logic             set_fail
);
  seq_state_e state_q, state_d;
  logic       cmd_ok, launch, reject, finish;

  assign cmd_ok = (wr_key == UNLOCK_KEY) && (wr_cmd == ERASE_CMD);
  assign launch = (state_q == SEQ_IDLE) && start_wr && cmd_ok;
  assign reject = (state_q == SEQ_IDLE) && start_wr && !cmd_ok;
  assign finish = (state_q == SEQ_ERASE) && erase_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (launch) state_d = SEQ_ERASE;
      SEQ_ERASE: if (finish) state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign busy     = (state_q == SEQ_ERASE);
  assign set_done = reject || finish;
  assign set_fail = reject || (finish && erase_err);
endmodule

// File: rtl/flash_wipe_flags.sv
module flash_wipe_flags
  import flash_wipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_done,
  input  logic              set_fail,
  output logic              done_q,
  output logic              fail_q,
  output logic              den_q,
  output logic              fen_q,
  output logic              irq_q
);
  logic done_d, fail_d, den_d, fen_d, irq_d;
  logic clr_done, clr_fail;
  logic unused_wdata;

  assign unused_wdata = ^{wdata[DATA_W-1:FEN_BIT+1], wdata[DEN_BIT-1:FAIL_BIT+1]};

  assign clr_done = wr && wdata[DONE_BIT];
  assign clr_fail = wr && wdata[FAIL_BIT];

  always_comb begin
    done_d = set_done || (done_q && !clr_done);
    fail_d = set_fail || (fail_q && !clr_fail);
    den_d  = wr ? wdata[DEN_BIT] : den_q;
    fen_d  = wr ? wdata[FEN_BIT] : fen_q;
    irq_d  = (done_q && den_q) || (fail_q && fen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      den_q  <= 1'b0;
      fen_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      fail_q <= fail_d;
      den_q  <= den_d;
      fen_q  <= fen_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/flash_wipe_regs.sv
module flash_wipe_regs
  import flash_wipe_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              fail,
  input  logic              den,
  input  logic              fen,
  output logic [DIV_W-1:0]  div_q,
  output logic [DATA_W-1:0] rdata
);
  logic [KEY_W-1:0] key_q, key_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [DIV_W-1:0] div_d;
  logic             ctrl_wr, div_wr;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:CMD_LSB+CMD_W];
  assign ctrl_wr = we && (addr == A_CTRL);
  assign div_wr  = we && (addr == A_DIV);

  always_comb begin
    key_d = ctrl_wr ? wdata[KEY_LSB +: KEY_W] : key_q;
    cmd_d = ctrl_wr ? wdata[CMD_LSB +: CMD_W] : cmd_q;
    div_d = div_wr  ? wdata[DIV_W-1:0]        : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      cmd_q <= '0;
      div_q <= '0;
    end else begin
      key_q <= key_d;
      cmd_q <= cmd_d;
      div_q <= div_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[KEY_LSB +: KEY_W] = key_q;
        rdata[CMD_LSB +: CMD_W] = cmd_q;
        rdata[START_BIT]        = busy;
        rdata[BUSY_BIT]         = busy;
      end
      A_DIV:  rdata[DIV_W-1:0] = div_q;
      A_FLAG: begin
        rdata[DONE_BIT] = done;
        rdata[FAIL_BIT] = fail;
        rdata[DEN_BIT]  = den;
        rdata[FEN_BIT]  = fen;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_wipe_ctl.sv
module flash_wipe_ctl
  import flash_wipe_pkg::*;
#(
  parameter int                DIV_W      = 8,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY = 4'h2,
  parameter logic [CMD_W-1:0]  ERASE_CMD  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              fl_erase_req_o,
  output logic              fl_tick_o,
  input  logic              fl_erase_done_i,
  input  logic              fl_error_i,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_sync;
  logic             busy, set_done, set_fail;
  logic             done_flag, fail_flag, done_en, fail_en;
  logic             start_wr, flag_wr;
  logic [DIV_W-1:0] div_val;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  assign start_wr = reg_we_i && (reg_addr_i == A_CTRL) && reg_wdata_i[START_BIT];
  assign flag_wr  = reg_we_i && (reg_addr_i == A_FLAG);

  flash_wipe_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .busy(busy), .done(done_flag), .fail(fail_flag),
    .den(done_en), .fen(fail_en), .div_q(div_val), .rdata(reg_rdata_o)
  );

  flash_wipe_seq #(.UNLOCK_KEY(UNLOCK_KEY), .ERASE_CMD(ERASE_CMD)) u_seq (
    .clk(clk), .rst_n(rst_n_sync), .start_wr(start_wr),
    .wr_key(reg_wdata_i[KEY_LSB +: KEY_W]), .wr_cmd(reg_wdata_i[CMD_LSB +: CMD_W]),
    .erase_done(fl_erase_done_i), .erase_err(fl_error_i),
    .busy(busy), .set_done(set_done), .set_fail(set_fail)
  );

  flash_wipe_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n_sync), .run(busy), .div(div_val), .tick(fl_tick_o)
  );

  flash_wipe_flags u_flags (
    .clk(clk), .rst_n(rst_n_sync), .wr(flag_wr), .wdata(reg_wdata_i),
    .set_done(set_done), .set_fail(set_fail), .done_q(done_flag),
    .fail_q(fail_flag), .den_q(done_en), .fen_q(fail_en), .irq_q(irq_o)
  );

  assign fl_erase_req_o = busy;
endmodule

// File: rtl/flash_wipe_ctl_chk.sv
module flash_wipe_ctl_chk
  import flash_wipe_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              busy,
  input logic              tick,
  input logic              fdone,
  input logic              ferr,
  input logic              done,
  input logic              fail,
  input logic              den,
  input logic              fen,
  input logic              irq
);
  logic start_w, good_w;
  assign start_w = we && (addr == A_CTRL) && wdata[START_BIT];
  assign good_w  = (wdata[KEY_LSB +: KEY_W] == 4'h2) && (wdata[CMD_LSB +: CMD_W] == 8'hAA);

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_w && good_w) |=> busy);
  a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_w && !good_w) |=> (!busy && done && fail));
  a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fdone) |=> busy);
  a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fdone) |=> (!busy && done && (fail || !$past(ferr))));
  a_r5_err_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fdone && ferr) |=> fail);
  a_r6_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tick);
  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past((done && den) || (fail && fen))));
endmodule

bind flash_wipe_ctl flash_wipe_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .we(reg_we_i), .addr(reg_addr_i),
  .wdata(reg_wdata_i), .busy(busy), .tick(fl_tick_o), .fdone(fl_erase_done_i),
  .ferr(fl_error_i), .done(done_flag), .fail(fail_flag), .den(done_en),
  .fen(fail_en), .irq(irq_o)
);

// File: tb/flash_wipe_ctl_test.sv
module flash_wipe_ctl_test;
  localparam int ERASE_TICKS = 5;
  localparam logic [13:0] VEC [7] = '{
    {4'h2, 8'hAA, 1'b0, 1'b1},
    {4'h2, 8'hAA, 1'b1, 1'b1},
    {4'h3, 8'hAA, 1'b0, 1'b0},
    {4'h2, 8'h55, 1'b0, 1'b0},
    {4'h0, 8'h00, 1'b0, 1'b0},
    {4'hF, 8'hAA, 1'b0, 1'b0},
    {4'h2, 8'hAB, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req, tick, fdone, irq;
  logic        err_in = 1'b0;
  logic [3:0]  tcnt;
  int          checks = 0, errors = 0;
  int          busy_cycles = 0, tick_count = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  flash_wipe_ctl uut (
    .clk(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fl_erase_req_o(req),
    .fl_tick_o(tick), .fl_erase_done_i(fdone), .fl_error_i(err_in), .irq_o(irq)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   tcnt <= '0;
    else if (!req) tcnt <= '0;
    else if (tick) tcnt <= tcnt + 1'b1;
  end
  assign fdone = req && tick && (tcnt == 4'(ERASE_TICKS - 1));

  always @(negedge clk) begin
    if (req) busy_cycles++;
    if (req && tick) tick_count++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [3:0] k, input logic [7:0] c, input logic s);
    logic [31:0] w;
    w = '0;
    w[3:0] = k;
    w[15:8] = c;
    w[16] = s;
    return w;
  endfunction

  task automatic wait_idle();
    for (int n = 0; n < 2000 && req; n++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, rv); chk("R1 ctrl", rv, 32'h0);
    rd(2'd1, rv); chk("R1 div", rv, 32'h0);
    rd(2'd2, rv); chk("R1 flags", rv, 32'h0);
    chk("R1 irq/req/tick", {29'b0, irq, req, tick}, 32'h0);

    // R2 R3 R5 R10 vector table
    for (int i = 0; i < 7; i++) begin
      logic [13:0] v;
      v = VEC[i];
      err_in = v[1];
      wr(2'd0, ctrl_word(v[13:10], v[9:2], 1'b1));
      chk($sformatf("R2/R3 vec%0d req", i), {31'b0, req}, {31'b0, v[0]});
      if (v[0]) begin
        rd(2'd0, rv); chk($sformatf("R2 vec%0d start+busy", i), rv[17:16], 2'b11);
      end
      wait_idle();
      rd(2'd2, rv); chk($sformatf("R5/R3 vec%0d flags", i), rv, {30'b0, v[1] | ~v[0], 1'b1});
      rd(2'd0, rv); chk($sformatf("R5/R10 vec%0d ctrl", i), rv, ctrl_word(v[13:10], v[9:2], 1'b0));
      wr(2'd2, 32'h3);
      rd(2'd2, rv); chk($sformatf("R7 vec%0d cleared", i), rv, 32'h0);
    end
    err_in = 1'b0;

    // R6 divider timing, R10 div readback
    wr(2'd1, 32'h3);
    rd(2'd1, rv); chk("R10 div readback", rv, 32'h3);
    busy_cycles = 0; tick_count = 0;
    wr(2'd0, ctrl_word(4'h2, 8'hAA, 1'b1));
    wait_idle();
    chk("R6 busy length D=3", busy_cycles, ERASE_TICKS * 4);
    chk("R6 tick count D=3", tick_count, ERASE_TICKS);
    wr(2'd2, 32'h3);

    // R4 start while busy ignored
    busy_cycles = 0; tick_count = 0;
    wr(2'd0, ctrl_word(4'h2, 8'hAA, 1'b1));
    wr(2'd0, ctrl_word(4'h2, 8'h11, 1'b1));
    wr(2'd0, ctrl_word(4'h2, 8'hAA, 1'b1));
    wait_idle();
    chk("R4 busy length unchanged", busy_cycles, ERASE_TICKS * 4);
    chk("R4 tick count unchanged", tick_count, ERASE_TICKS);
    rd(2'd2, rv); chk("R4 no fail from ignored start", rv, 32'h1);
    repeat (3) @(negedge clk);
    chk("R4 no second erase", {31'b0, req}, 32'h0);
    wr(2'd2, 32'h3);
    wr(2'd1, 32'h0);

    // R7 write-one-to-clear
    wr(2'd0, ctrl_word(4'h0, 8'h00, 1'b1));
    wr(2'd2, 32'h0);
    rd(2'd2, rv); chk("R7 write 0 keeps", rv, 32'h3);
    wr(2'd2, 32'h1);
    rd(2'd2, rv); chk("R7 clear done only", rv, 32'h2);
    wr(2'd2, 32'h2);
    rd(2'd2, rv); chk("R7 clear fail", rv, 32'h0);

    // R9 interrupt
    wr(2'd2, 32'h100);
    rd(2'd2, rv); chk("R10 enable readback", rv, 32'h100);
    wr(2'd0, ctrl_word(4'h1, 8'hAA, 1'b1));
    chk("R9 irq lags flags", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq from done", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h103);
    chk("R9 irq held one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h200);
    wr(2'd0, ctrl_word(4'h2, 8'hAA, 1'b1));
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R9 done masked", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h201);
    err_in = 1'b1;
    wr(2'd0, ctrl_word(4'h2, 8'hAA, 1'b1));
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R9 irq from fail", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h3);

    // R8 completion and clear in the same edge
    wr(2'd0, ctrl_word(4'h2, 8'hAA, 1'b1));
    for (int n = 0; n < 200 && !fdone; n++) @(negedge clk);
    wr(2'd2, 32'h3);
    rd(2'd2, rv); chk("R8 set wins over clear", rv, 32'h3);
    chk("R8 erase ended", {31'b0, req}, 32'h0);
    err_in = 1'b0;
    wr(2'd2, 32'h3);

    // R10 relock
    wr(2'd0, ctrl_word(4'h2, 8'hAA, 1'b0));
    rd(2'd0, rv); chk("R10 unlocked readback", rv, 32'h0000AA02);
    wr(2'd0, ctrl_word(4'h9, 8'hAA, 1'b1));
    chk("R10 relocked start rejected", {31'b0, req}, 32'h0);
    rd(2'd2, rv); chk("R10 relock fail flags", rv, 32'h3);
    rd(2'd0, rv); chk("R10 relocked key", rv, 32'h0000AA09);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule